// File: doc/BRIEF.md
# Min/Max Peak-Capture Decimator

This block turns a dense stream of 10-bit unsigned converter codes into a much shorter stream of display points. Each display point stands for a group of consecutive accepted samples, and the group length comes from a 16-bit run-time setting. The block looks at every sample in the group. It does not pick one representative sample. Each point reports both the smallest and the largest code seen in its group. A spike one sample wide therefore still shows in the output when a single point covers thousands of samples, for example about 2667 samples per point when a few milliseconds are spread across a few hundred display columns.

Samples arrive with a valid qualifier, a start-of-frame marker and an end-of-frame marker. A start-of-frame sample always opens a fresh group. An end-of-frame sample closes whatever group is open, even if it is short, and that point is flagged as the last of the frame. Every point is presented as a single-cycle strobe together with its minimum, its maximum and its last-point flag.

Top module: `peak_decimator`

## Requirements
- R1: While `rst_n` is low, and after its release until the first point, `pt_valid` and `pt_last` are 0 and `pt_min` and `pt_max` are 0.
- R2: When `smp_valid` is high the sample is accepted. A group closes on the accepted sample that brings its count up to `grp_size`. Its point then carries the minimum and the maximum of exactly those accepted samples. Cycles with `smp_valid` low do not count and do not affect any value.
- R3: `pt_valid` is high for exactly one cycle, the cycle after the closing sample is accepted. In every other cycle it is low.
- R4: With `grp_size` = 1 every accepted sample produces a point with `pt_min` = `pt_max` = that sample.
- R5: `grp_size` = 0 behaves the same as `grp_size` = 1.
- R6: The running minimum and maximum start from the first sample of each group, not from constants. A group whose samples are all 1023 reports a minimum of 1023. A group whose samples are all 0 reports a maximum of 0.
- R7: An accepted sample with `smp_sof` high is the first sample of a new group. Samples of an unfinished earlier group are discarded and produce no point.
- R8: An accepted sample with `smp_eof` high closes the current group whatever its count, and that point has `pt_last` = 1. Every point closed by the count alone has `pt_last` = 0.
- R9: A single-sample excursion at any position inside a group (first, middle or last) appears in that group's `pt_min` or `pt_max`.
- R10: Group sizes up to 65535 are supported. A 2667-sample group reports the extremes of all 2667 samples.
- R11: Every point satisfies `pt_min` <= `pt_max`. Both values are codes that were accepted within that group.
- R12: A sample with both `smp_sof` and `smp_eof` high forms a one-sample group of its own, which is flagged last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | 10 | Unsigned sample code |
| smp_sof | input | 1 | Sample is the first of a frame |
| smp_eof | input | 1 | Sample is the last of a frame |
| grp_size | input | 16 | Samples per display point (0 acts as 1) |
| pt_valid | output | 1 | Display point strobe, one cycle |
| pt_min | output | 10 | Smallest code in the group |
| pt_max | output | 10 | Largest code in the group |
| pt_last | output | 1 | Point closes the frame |

## Verification
Each point is due exactly one cycle after its closing sample is accepted, because the only register between the sample and the output is the point register. The bench therefore drives a sample on a falling edge and reads the outputs on the next falling edge. At that read it expects `pt_valid` high precisely when its own model says the sample closed a group. When no group closed it expects `pt_valid` low. Idle cycles, group-size changes and frame markers are checked in the same way, one cycle after each stimulus.

// File: rtl/peak_decim_pkg.sv
// Package: shared defaults for the peak-capture decimator.
// Assumes: consumers take widths as parameters defaulting to these values.
package peak_decim_pkg;
    localparam int DEF_SAMPLE_W = 10;
    localparam int DEF_COUNT_W  = 16;

    // Kind of extreme a tracker follows.
    typedef enum logic {
        EXT_MIN = 1'b0,
        EXT_MAX = 1'b1
    } ext_kind_e;
endpackage

// File: rtl/pd_group_counter.sv
// Module: pd_group_counter
// Counts accepted samples in the open group and flags the first and the
// closing sample of each group.
// Assumes: grp_size may change at any time; a value of 0 is taken as 1.
module pd_group_counter #(
    parameter int COUNT_W = peak_decim_pkg::DEF_COUNT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_valid,
    input  logic               smp_sof,
    input  logic               smp_eof,
    input  logic [COUNT_W-1:0] grp_size,
    output logic               grp_first,
    output logic               grp_close
);
    localparam int POS_W = COUNT_W + 1;

    logic [COUNT_W-1:0] taken_q;
    logic [POS_W-1:0]   size_eff;
    logic [POS_W-1:0]   pos;

    // Derive the position of the current sample inside its group.
    always_comb begin
        size_eff  = (grp_size == '0) ? POS_W'(1) : POS_W'(grp_size);
        grp_first = smp_sof || (taken_q == '0);
        pos       = grp_first ? POS_W'(1) : (POS_W'(taken_q) + POS_W'(1));
        grp_close = smp_valid && ((pos >= size_eff) || smp_eof);
    end

    // Hold the number of samples already taken into the open group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_q <= '0;
        end else if (smp_valid) begin
            taken_q <= grp_close ? '0 : pos[COUNT_W-1:0];
        end
    end
endmodule

// File: rtl/pd_extreme_track.sv
// Module: pd_extreme_track
// Follows the running minimum or maximum (picked by KIND) of the open group.
// ext_next is the extreme including the present sample.
// Assumes: grp_first marks the sample that seeds a new group.
module pd_extreme_track #(
    parameter int                        SAMPLE_W = peak_decim_pkg::DEF_SAMPLE_W,
    parameter peak_decim_pkg::ext_kind_e KIND     = peak_decim_pkg::EXT_MIN
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                grp_first,
    output logic [SAMPLE_W-1:0] ext_next
);
    logic [SAMPLE_W-1:0] acc_q;
    logic                take_new;

    // Compare in the direction chosen by KIND.
    generate
        if (KIND == peak_decim_pkg::EXT_MIN) begin : g_min
            assign take_new = smp_data < acc_q;
        end else begin : g_max
            assign take_new = smp_data > acc_q;
        end
    endgenerate

    // Seed from the first sample, otherwise keep the stronger value.
    always_comb begin
        ext_next = (grp_first || take_new) ? smp_data : acc_q;
    end

    // Store the running extreme on every accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (smp_valid) begin
            acc_q <= ext_next;
        end
    end
endmodule

// File: rtl/pd_point_reg.sv
// Module: pd_point_reg
// Registers one display point when a group closes and strobes it once.
// Assumes: load is high for one cycle per closed group.
module pd_point_reg #(
    parameter int SAMPLE_W = peak_decim_pkg::DEF_SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] min_in,
    input  logic [SAMPLE_W-1:0] max_in,
    input  logic                last_in,
    output logic                pt_valid,
    output logic [SAMPLE_W-1:0] pt_min,
    output logic [SAMPLE_W-1:0] pt_max,
    output logic                pt_last
);
    // Raise the strobe for the cycle after the closing sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pt_valid <= 1'b0;
            pt_last  <= 1'b0;
        end else begin
            pt_valid <= load;
            pt_last  <= load && last_in;
        end
    end

    // Capture the pair of extremes of the closing group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pt_min <= '0;
            pt_max <= '0;
        end else if (load) begin
            pt_min <= min_in;
            pt_max <= max_in;
        end
    end
endmodule

// File: rtl/peak_decimator.sv
// Module: peak_decimator (top)
// Reduces a sample stream to min/max display points, one per group of
// grp_size accepted samples; frame markers open and close groups early.
// Assumes: unsigned sample codes; no back-pressure on the point output.
module peak_decimator #(
    parameter int SAMPLE_W = peak_decim_pkg::DEF_SAMPLE_W,
    parameter int COUNT_W  = peak_decim_pkg::DEF_COUNT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                smp_sof,
    input  logic                smp_eof,
    input  logic [COUNT_W-1:0]  grp_size,
    output logic                pt_valid,
    output logic [SAMPLE_W-1:0] pt_min,
    output logic [SAMPLE_W-1:0] pt_max,
    output logic                pt_last
);
    logic                grp_first;
    logic                grp_close;
    logic [SAMPLE_W-1:0] min_next;
    logic [SAMPLE_W-1:0] max_next;

    pd_group_counter #(.COUNT_W(COUNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_sof   (smp_sof),
        .smp_eof   (smp_eof),
        .grp_size  (grp_size),
        .grp_first (grp_first),
        .grp_close (grp_close)
    );

    pd_extreme_track #(.SAMPLE_W(SAMPLE_W), .KIND(peak_decim_pkg::EXT_MIN)) u_min (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .grp_first (grp_first),
        .ext_next  (min_next)
    );

    pd_extreme_track #(.SAMPLE_W(SAMPLE_W), .KIND(peak_decim_pkg::EXT_MAX)) u_max (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .grp_first (grp_first),
        .ext_next  (max_next)
    );

    pd_point_reg #(.SAMPLE_W(SAMPLE_W)) u_point (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (grp_close),
        .min_in   (min_next),
        .max_in   (max_next),
        .last_in  (smp_eof),
        .pt_valid (pt_valid),
        .pt_min   (pt_min),
        .pt_max   (pt_max),
        .pt_last  (pt_last)
    );
endmodule

// File: rtl/peak_decimator_chk.sv
// Module: peak_decimator_chk
// Port-level properties of the decimator, bound to every instance.
// Assumes: reset is synchronous and active low.
module peak_decimator_chk #(
    parameter int SAMPLE_W = 10,
    parameter int COUNT_W  = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                smp_valid,
    input logic [SAMPLE_W-1:0] smp_data,
    input logic                smp_sof,
    input logic                smp_eof,
    input logic [COUNT_W-1:0]  grp_size,
    input logic                pt_valid,
    input logic [SAMPLE_W-1:0] pt_min,
    input logic [SAMPLE_W-1:0] pt_max,
    input logic                pt_last
);
    AST_NO_POINT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !pt_valid); // R3
    AST_ORDERED_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        pt_valid |-> (pt_min <= pt_max)); // R11
    AST_CLOSER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && pt_valid == pt_valid) ##1 pt_valid |->
        (pt_min <= $past(smp_data) && $past(smp_data) <= pt_max)); // R2
    AST_UNIT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && grp_size <= 16'd1) |=>
        (pt_valid && pt_min == $past(smp_data) && pt_max == $past(smp_data))); // R4
    AST_EOF_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_eof) |=> (pt_valid && pt_last)); // R8
    AST_LAST_NEEDS_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        pt_last |-> (pt_valid && $past(smp_eof))); // R8
endmodule

bind peak_decimator peak_decimator_chk #(.SAMPLE_W(SAMPLE_W), .COUNT_W(COUNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .smp_sof   (smp_sof),
    .smp_eof   (smp_eof),
    .grp_size  (grp_size),
    .pt_valid  (pt_valid),
    .pt_min    (pt_min),
    .pt_max    (pt_max),
    .pt_last   (pt_last)
);

// File: tb/tb_peak_decimator.sv
module tb_peak_decimator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [9:0]  smp_data = '0;
    logic        smp_sof = 1'b0;
    logic        smp_eof = 1'b0;
    logic [15:0] grp_size = 16'd4;
    logic        pt_valid;
    logic [9:0]  pt_min;
    logic [9:0]  pt_max;
    logic        pt_last;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    int m_cnt = 0;
    int m_min = 0;
    int m_max = 0;

    peak_decimator dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .smp_sof(smp_sof), .smp_eof(smp_eof), .grp_size(grp_size),
        .pt_valid(pt_valid), .pt_min(pt_min), .pt_max(pt_max), .pt_last(pt_last)
    );

    always #4 clk = ~clk;

    function automatic int fmin(int a, int b);
        return (a < b) ? a : b;
    endfunction

    function automatic int fmax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int eff_size(int s);
        return (s == 0) ? 1 : s;
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge; check outputs at the next falling edge.
    task automatic step(bit v, int d, bit sof, bit eof, string tag);
        bit exp_v = 1'b0;
        int exp_min = 0, exp_max = 0;
        bit exp_last = 1'b0;
        if (v) begin
            bit first = sof || (m_cnt == 0);
            int pos = first ? 1 : m_cnt + 1;
            int nmin = first ? d : fmin(m_min, d);
            int nmax = first ? d : fmax(m_max, d);
            if (pos >= eff_size(int'(grp_size)) || eof) begin
                exp_v = 1'b1; exp_min = nmin; exp_max = nmax; exp_last = eof;
                m_cnt = 0;
            end else begin
                m_cnt = pos;
            end
            m_min = nmin; m_max = nmax;
        end
        smp_valid = v; smp_data = d[9:0]; smp_sof = sof; smp_eof = eof;
        @(negedge clk);
        smp_valid = 1'b0; smp_sof = 1'b0; smp_eof = 1'b0;
        chk(pt_valid == exp_v, tag, "pt_valid", int'(pt_valid), int'(exp_v));
        if (exp_v && pt_valid) begin
            chk(pt_min == exp_min[9:0], tag, "pt_min", int'(pt_min), exp_min);
            chk(pt_max == exp_max[9:0], tag, "pt_max", int'(pt_max), exp_max);
            chk(pt_last == exp_last, tag, "pt_last", int'(pt_last), int'(exp_last));
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!pt_valid && !pt_last, "R1", "valid/last in reset", int'(pt_valid), 0);
        chk(pt_min == 0 && pt_max == 0, "R1", "min/max in reset", int'(pt_max), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!pt_valid && pt_min == 0, "R1", "after release", int'(pt_valid), 0);

        // R2 and R3: groups of 4 with idle gaps inside
        grp_size = 16'd4;
        step(1, 300, 1, 0, "R3"); step(1, 12, 0, 0, "R3");
        step(0, 1000, 0, 0, "R2"); step(1, 700, 0, 0, "R2");
        step(1, 45, 0, 0, "R2");  step(0, 0, 0, 0, "R3");
        // R6: seeding from first sample
        for (int i = 0; i < 4; i++) step(1, 1023, 0, 0, "R6");
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, "R6");
        // R4: unit groups
        grp_size = 16'd1;
        for (int i = 0; i < 5; i++) step(1, i * 200 + 7, 0, 0, "R4");
        // R5: zero acts as one
        grp_size = 16'd0;
        for (int i = 0; i < 4; i++) step(1, 900 - i * 100, 0, 0, "R5");
        // R7: start-of-frame discards an open group
        grp_size = 16'd3;
        step(1, 5, 0, 0, "R7"); step(1, 1000, 0, 0, "R7");
        step(1, 400, 1, 0, "R7"); step(1, 401, 0, 0, "R7"); step(1, 402, 0, 0, "R7");
        // R8: end-of-frame flushes a partial group
        step(1, 600, 0, 0, "R8"); step(1, 20, 0, 1, "R8");
        step(1, 33, 0, 0, "R8"); step(1, 34, 0, 0, "R8"); step(1, 35, 0, 0, "R8");
        // R12: sof and eof on one sample
        step(1, 77, 0, 0, "R12"); step(1, 222, 1, 1, "R12"); step(0, 0, 0, 0, "R12");
        // R9 / R10: narrow glitches in a 2667-sample group
        grp_size = 16'd2667;
        for (int g = 0; g < 3; g++) begin
            int at = (g == 0) ? 0 : ((g == 1) ? 1333 : 2666);
            for (int i = 0; i < 2667; i++) begin
                int d = 512;
                if (i == at) d = (g == 1) ? 3 : 1020;
                step(1, d, (g == 0 && i == 0), 0, (i == 2666) ? "R10" : "R9");
            end
        end
        // R11 and R2: constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            bit v = ($urandom % 4) != 0;
            bit sof = ($urandom % 40) == 0;
            bit eof = ($urandom % 50) == 0;
            if (m_cnt == 0 && ($urandom % 8) == 0) grp_size = 16'($urandom % 10);
            step(v, int'($urandom % 1024), sof, eof, "R11");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule